// File: doc/BRIEF.md
# MDIO Management Register Front End

This block lets software reach PHY management registers through four 16-bit host registers. The host loads a data word if it plans a write, then writes a command word. The command word holds a PHY address, a register number and exactly one request bit, either read or write. The block then shifts a complete management frame out on the serial clock and data pins. On a read it captures the 16 returned bits into a read-back register.

The request bit stays set while the frame is in flight and clears itself when the last bit has been clocked. Software therefore polls the command register to learn when the transfer is done. The serial clock comes from the system clock through a divider that software can set. The data pin is split into an output, an output enable and an input, so that the pad or a pull-up can be modelled at the chip level. An unconnected PHY leaves the line floating high, so a read from it returns all ones.

Top module: `mdio_host_regs`

## Requirements
- R1: After reset the command, write-data and read-data registers read 0, the divider register (offset 3) reads its default of 4, MDC is low and MDIO is not driven.
- R2: The command register (offset 0) takes the PHY address in bits 12:8 and the register number in bits 4:0. A read frame carries opcode 10 and a write frame carries opcode 01, followed by those two fields, MSB first.
- R3: A request bit (bit 13 read, bit 14 write) reads back as set while its frame runs and clears by itself once the frame ends.
- R4: A write frame sends the 16-bit word held in the write-data register (offset 1), preceded by the turnaround pattern 10.
- R5: After a read frame, the read-data register (offset 2) holds the 16 bits the PHY returned, first bit as MSB. The block releases MDIO from the turnaround onward.
- R6: A read from a PHY that never drives the line returns 0xFFFF.
- R7: Every frame starts with exactly 32 ones followed by the start pattern 01.
- R8: Each MDC phase, high or low, lasts the divider value plus one system clocks.
- R9: A command written while a frame is running is ignored, and the running frame completes unchanged.
- R10: A command word with both request bits set, or with neither set, starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Host register write strobe |
| reg_addr | input | 2 | Register select: 0 command, 1 write data, 2 read data, 3 divider |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Contents of the selected register |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in, as seen at the pad |

## Verification
The hardest case to reach is a command that arrives in the middle of a running frame. It has to land while the request bit is still set, and its effect shows only later, as a missing second frame and an unchanged read result. The bench starts a read, waits a few dozen clocks, and then writes a conflicting write command. It then checks the read value, the fields in the command register and the PHY model's captured frame after a long idle period. A PHY model in the bench decodes each frame from the pins and answers reads only at its own address, so the all-ones result of an absent PHY comes from the pull-up path and not from the design.

// File: rtl/mdio_host_regs.sv
module mdio_host_regs #(
  parameter int DIV_W    = 8,
  parameter int DIV_INIT = 4,
  parameter int PRE_LEN  = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int TOT   = PRE_LEN + 32;
  localparam int CNT_W = $clog2(TOT);
  localparam logic [CNT_W-1:0] LAST     = CNT_W'(TOT - 1);
  localparam logic [CNT_W-1:0] PRE_END  = CNT_W'(PRE_LEN);
  localparam logic [CNT_W-1:0] TA_POS   = CNT_W'(PRE_LEN + 14);
  localparam logic [CNT_W-1:0] DATA_POS = CNT_W'(PRE_LEN + 16);

  logic             rd_pend, wr_pend, mdc_q;
  logic [15:0]      wd_q, rd_q, rsh;
  logic [31:0]      fr;
  logic [DIV_W-1:0] div_q, hc;
  logic [CNT_W-1:0] cnt;

  wire busy  = rd_pend | wr_pend;
  wire start = reg_we && reg_addr == 2'd0 && !busy && (reg_wdata[13] ^ reg_wdata[14]);
  wire tick  = busy && hc == div_q;
  wire rise  = tick && !mdc_q;
  wire fall  = tick && mdc_q;
  wire done  = fall && cnt == LAST;
  wire [4:0] bit_idx = 5'(LAST - cnt);
  wire unused_bits = ^{reg_wdata[15], reg_wdata[7:5]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_pend <= 1'b0;
      wr_pend <= 1'b0;
      mdc_q   <= 1'b0;
      wd_q    <= '0;
      rd_q    <= '0;
      rsh     <= '0;
      fr      <= '0;
      div_q   <= DIV_W'(DIV_INIT);
      hc      <= '0;
      cnt     <= '0;
    end else begin
      if (reg_we && reg_addr == 2'd1) wd_q <= reg_wdata;
      if (reg_we && reg_addr == 2'd3 && !busy) div_q <= reg_wdata[DIV_W-1:0];
      if (start) begin
        rd_pend <= reg_wdata[13];
        wr_pend <= reg_wdata[14];
        fr      <= {2'b01, reg_wdata[13] ? 2'b10 : 2'b01, reg_wdata[12:8], reg_wdata[4:0], 2'b10, wd_q};
        cnt     <= '0;
        hc      <= '0;
        mdc_q   <= 1'b0;
      end else if (busy) begin
        hc <= tick ? '0 : hc + 1'b1;
        if (tick) mdc_q <= ~mdc_q;
        if (rise && rd_pend && cnt >= DATA_POS) rsh <= {rsh[14:0], mdio_i};
        if (fall) cnt <= cnt + 1'b1;
        if (done) begin
          rd_pend <= 1'b0;
          wr_pend <= 1'b0;
          cnt     <= '0;
          if (rd_pend) rd_q <= rsh;
        end
      end
    end
  end

  assign mdc     = mdc_q;
  assign mdio_o  = (cnt < PRE_END) ? 1'b1 : fr[bit_idx];
  assign mdio_oe = busy && !(rd_pend && cnt >= TA_POS);

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {1'b0, wr_pend, rd_pend, fr[27:23], 3'b000, fr[22:18]};
      2'd1:    reg_rdata = wd_q;
      2'd2:    reg_rdata = rd_q;
      default: reg_rdata = 16'(div_q);
    endcase
  end
endmodule

// File: rtl/mdio_host_regs_chk.sv
module mdio_host_regs_chk #(
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_pend,
  input logic             wr_pend,
  input logic             mdc,
  input logic             mdio_oe,
  input logic [CNT_W-1:0] cnt,
  input logic             reg_we,
  input logic [1:0]       reg_addr,
  input logic [15:0]      reg_wdata,
  input logic [31:0]      fr
);
  wire busy = rd_pend | wr_pend;

  // R3
  pend_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_pend, wr_pend}));

  // R1
  idle_mdc_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  // R5
  oe_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> busy);

  // R9
  busy_cmd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && reg_we && reg_addr == 2'd0 |=> $stable(fr) && $stable({rd_pend, wr_pend}));

  // R10
  bad_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && reg_we && reg_addr == 2'd0 && (reg_wdata[13] == reg_wdata[14]) |=> !busy);

  // R3
  start_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> cnt == '0 && !mdc);
endmodule

bind mdio_host_regs mdio_host_regs_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_pend(rd_pend), .wr_pend(wr_pend),
  .mdc(mdc), .mdio_oe(mdio_oe), .cnt(cnt), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .fr(fr)
);

// File: tb/mdio_host_regs_test.sv
module mdio_host_regs_test;
  localparam int MODEL_PHY = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;

  // PHY model state
  logic        drv_en = 1'b0, drv_val = 1'b0;
  int          st = 0, pos = 0, ones = 0;
  logic [11:0] hdr = '0;
  logic [1:0]  ta = '0;
  logic [15:0] dsh = '0, rdat = '0;
  logic        rd_hit = 1'b0;
  logic [15:0] mem [32];
  logic [31:0] wmask = '0;
  int          cap_pre = 0, frames = 0;
  logic [1:0]  cap_op = '0, cap_ta = '0;
  logic [4:0]  cap_phy = '0, cap_reg = '0;
  logic [15:0] cap_data = '0;

  always #10 clk = ~clk;

  mdio_host_regs uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  assign mdio_i = drv_en ? drv_val : (mdio_oe ? mdio_o : 1'b1);

  function automatic logic [15:0] phy_val(input logic [4:0] r);
    return wmask[r] ? mem[r] : (16'hA500 + 16'(r));
  endfunction

  always @(posedge mdc) begin
    case (st)
      0: if (mdio_i) ones++;
         else if (ones >= 32) begin st = 1; cap_pre = ones; end
         else ones = 0;
      1: if (mdio_i) begin st = 2; pos = 0; hdr = '0; end
         else begin st = 0; ones = 0; end
      2: begin
        hdr = {hdr[10:0], mdio_i}; pos++;
        if (pos == 12) begin
          st = 3; pos = 0;
          cap_op = hdr[11:10]; cap_phy = hdr[9:5]; cap_reg = hdr[4:0];
          rd_hit = hdr[11:10] == 2'b10 && hdr[9:5] == 5'(MODEL_PHY);
          rdat = phy_val(hdr[4:0]);
        end
      end
      3: begin
        ta = {ta[0], mdio_i}; pos++;
        if (pos == 2) begin st = 4; pos = 0; dsh = '0; cap_ta = ta; end
      end
      default: begin
        dsh = {dsh[14:0], mdio_i}; pos++;
        if (pos == 16) begin
          cap_data = dsh;
          if (cap_op == 2'b01 && cap_phy == 5'(MODEL_PHY)) begin
            mem[cap_reg] = dsh; wmask[cap_reg] = 1'b1;
          end
          frames++; st = 0; ones = 0; pos = 0;
        end
      end
    endcase
  end

  always @(negedge mdc) begin
    if (st == 3 && pos == 1 && rd_hit) begin drv_en = 1'b1; drv_val = 1'b0; end
    else if (st == 4 && rd_hit) begin drv_en = 1'b1; drv_val = rdat[15 - pos]; end
    else drv_en = 1'b0;
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      summary();
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_done(input logic [15:0] bitm);
    logic [15:0] v;
    int n = 0;
    rd(2'd0, v);
    check((v & bitm) == bitm, "R3 request bit set while running", int'(v & bitm), int'(bitm));
    while ((v & 16'h6000) != 0 && n < 5000) begin rd(2'd0, v); n++; end
    check((v & 16'h6000) == 0, "R3 request bit self-clears", int'(v & 16'h6000), 0);
  endtask

  function automatic logic [15:0] cmd(input bit w, input logic [4:0] p, input logic [4:0] r);
    return {1'b0, w, ~w, p, 3'b000, r};
  endfunction

  task automatic half_period(output int n);
    n = 0;
    @(posedge mdc);
    while (mdc) begin @(posedge clk); #1; n++; end
  endtask

  // {write, phy, reg, data-or-expected}
  localparam logic [26:0] VEC [9] = '{
    {1'b0, 5'd1, 5'd2,  16'hA502},
    {1'b1, 5'd1, 5'd4,  16'h01E1},
    {1'b0, 5'd1, 5'd4,  16'h01E1},
    {1'b1, 5'd1, 5'd0,  16'h3100},
    {1'b0, 5'd1, 5'd0,  16'h3100},
    {1'b0, 5'd3, 5'd2,  16'hFFFF},
    {1'b1, 5'd1, 5'd31, 16'h0000},
    {1'b0, 5'd1, 5'd31, 16'h0000},
    {1'b0, 5'd0, 5'd1,  16'hFFFF}
  };

  initial begin
    logic [15:0] v;
    int hp;
    bit low;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, v); check(v == 16'h0, "R1 command reset", int'(v), 0);
    rd(2'd1, v); check(v == 16'h0, "R1 write-data reset", int'(v), 0);
    rd(2'd2, v); check(v == 16'h0, "R1 read-data reset", int'(v), 0);
    rd(2'd3, v); check(v == 16'd4, "R1 divider default", int'(v), 4);
    check(!mdc && !mdio_oe, "R1 pins idle", int'({mdc, mdio_oe}), 0);

    for (int i = 0; i < 9; i++) begin
      logic        w = VEC[i][26];
      logic [4:0]  p = VEC[i][25:21];
      logic [4:0]  r = VEC[i][20:16];
      logic [15:0] d = VEC[i][15:0];
      if (w) wr(2'd1, d);
      wr(2'd0, cmd(w, p, r));
      wait_done(w ? 16'h4000 : 16'h2000);
      check(cap_pre == 32, "R7 preamble ones", cap_pre, 32);
      check(cap_op == (w ? 2'b01 : 2'b10), "R2 opcode", int'(cap_op), w ? 1 : 2);
      check(cap_phy == p && cap_reg == r, "R2 address fields", int'({cap_phy, cap_reg}), int'({p, r}));
      if (w) begin
        check(cap_ta == 2'b10, "R4 turnaround", int'(cap_ta), 2);
        check(cap_data == d, "R4 write data on line", int'(cap_data), int'(d));
      end else begin
        rd(2'd2, v);
        check(v == d, (p == 5'(MODEL_PHY)) ? "R5 read data" : "R6 absent PHY reads ones", int'(v), int'(d));
      end
    end

    // R8 divider 0 and 3
    wr(2'd3, 16'd0);
    wr(2'd0, cmd(1'b0, 5'd1, 5'd3));
    half_period(hp);
    check(hp == 1, "R8 half period div 0", hp, 1);
    wait_done(16'h0000);
    wr(2'd3, 16'd3);
    wr(2'd0, cmd(1'b0, 5'd1, 5'd3));
    half_period(hp);
    check(hp == 4, "R8 half period div 3", hp, 4);
    wait_done(16'h0000);
    rd(2'd2, v); check(v == 16'hA503, "R5 read data fast clock", int'(v), 16'hA503);

    // R9 command during a running frame
    wr(2'd1, 16'h1234);
    wr(2'd0, cmd(1'b0, 5'd1, 5'd7));
    repeat (40) @(posedge clk);
    wr(2'd0, cmd(1'b1, 5'd1, 5'd9));
    rd(2'd0, v);
    check(v == cmd(1'b0, 5'd1, 5'd7), "R9 command fields unchanged", int'(v), int'(cmd(1'b0, 5'd1, 5'd7)));
    wait_done(16'h0000);
    rd(2'd2, v); check(v == 16'hA507, "R9 running read completes", int'(v), 16'hA507);
    hp = frames;
    repeat (600) @(posedge clk);
    check(frames == hp, "R9 no second frame", frames, hp);
    check(!wmask[9], "R9 write not performed", int'(wmask[9]), 0);

    // R10 both or neither request bit
    wr(2'd0, 16'h6109);
    low = 1'b1;
    for (int k = 0; k < 50; k++) begin @(negedge clk); if (mdc) low = 1'b0; end
    rd(2'd0, v);
    check((v & 16'h6000) == 0 && low, "R10 both bits ignored", int'(v), 0);
    wr(2'd0, 16'h0109);
    for (int k = 0; k < 50; k++) begin @(negedge clk); if (mdc) low = 1'b0; end
    check(low && frames == hp, "R10 neither bit ignored", frames, hp);
    check(!mdio_oe, "R1 line released when idle", int'(mdio_oe), 0);

    summary();
  end
endmodule